// File: doc/BRIEF.md
# Successive Approximation Control Register

This block sequences the binary search of a successive-approximation analog-to-digital converter. The block drives an external DAC from its parallel bit register and reads back a single comparator decision every clock. After a start is detected, the most significant bit is raised as a trial. On each following rising edge the bit under trial is kept or dropped according to the comparator, and the next lower bit is raised. The bits that are already decided form the conversion result, and that result stays valid after the search ends.

The same decisions leave the block one at a time on a serial output. A ninth serial period follows the last bit so that a second register can be chained below this one. An end-of-conversion flag changes only on the falling clock edge. This gives the decision logic half a cycle to settle before the flag is seen. The flag can also be wired back to the start input, which makes the converter run continuously.

A build-time parameter chooses what the single mode input does. In one variant it is a synchronous master reset. In the other it is a feed-forward input that ends the conversion early, for a shorter word. For a shorter word, tie the output bit just below the intended least significant bit to this input. The bits below that point keep moving and carry no meaning.

Top module: `sar_ctrl`

## Requirements
- R1: While `rst` is sampled high at a rising edge, `bitsOut` and `serialOut` are 0, and `convDone` is 0 from the next falling edge. After reset, no conversion begins until a start is detected.
- R2: A start is detected at a rising edge where `startConv` is sampled 1 after being sampled 0 at the previous edge. The start applies even in the middle of a conversion. After the start edge, `bitsOut` holds only its top bit set (0x80 for 8 bits). In master-reset mode, holding `startConv` at 1 causes no further start.
- R3: At the k-th rising edge after a start (k = 1..WIDTH), bit WIDTH-k takes the comparator decision and bit WIDTH-k-1 is raised as the next trial. A decision of 1 keeps the bit and 0 clears it. `compIn` passes through a two-stage synchronizer, so the decision used at an edge is the `compIn` value that was sampled two rising edges earlier.
- R4: Once decided, a bit keeps its value until reset, master reset or the next start.
- R5: `convDone` falls at the falling edge after a start edge. In the normal case it rises at the falling edge after the edge that decides bit 0. In feed-forward mode it instead rises at the falling edge after the first rising edge of a running conversion at which `modeCtl` is sampled 1. The bits decided before that edge are correct.
- R6: In master-reset mode, `modeCtl` sampled 1 at a rising edge clears `bitsOut` and `serialOut` at that edge, and clears `convDone` at the next falling edge. Once `modeCtl` is released, a conversion starts at the first edge where `startConv` is sampled 1, even if it was already 1 at the previous edge. While `startConv` stays 0, the register stays clear.
- R7: In the period after decision edge k, `serialOut` carries the bit decided at that edge. In the period after the edge that follows the ending edge, `serialOut` carries the synchronized comparator value as a ninth bit.
- R8: `serialOut` is 0 in the period after a start edge and while reset or master reset clears the register. It is also 0 from the second period after `convDone` rises until the next decision.
- R9: In feed-forward mode, `startConv` sampled 1 while the conversion has ended starts a new conversion, with no low-to-high transition on `startConv` needed.
- R10: With `convDone` wired back to `startConv`, a new conversion starts every WIDTH+1 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. Decisions use the rising edge, and `convDone` uses the falling edge |
| rst | input | 1 | Synchronous power-on reset, active high |
| startConv | input | 1 | Start request, edge detected on the clock |
| compIn | input | 1 | Comparator decision, asynchronous to the clock |
| modeCtl | input | 1 | Master reset or feed-forward, selected by `FEED_FWD` |
| bitsOut | output | WIDTH | Trial and decided bits, to the DAC and as the result |
| serialOut | output | 1 | Decisions in serial form, most significant first |
| convDone | output | 1 | End of conversion, updated on the falling edge |

## Verification
The hardest state to reach from the ports is the interaction of the synchronizer latency with the search. The comparator value for a decision must be on `compIn` two edges before that decision is made. So the stimulus drives the first decision before the start edge and keeps running two steps ahead, which makes each random result word come out exactly as chosen. The feed-forward early end is reached by raising `modeCtl` at a chosen mid-search edge. Automatic restart is reached by holding `startConv` high through the end of a conversion. The master reset release with the start input already high is driven directly. The feedback mode is reached by copying `convDone` into `startConv` every cycle.

// File: rtl/sar_pkg.sv
package sar_pkg;
  // Per-cycle orders from the control to the bit register
  typedef struct packed {
    logic clearAll;    // master reset: empty register and serial line
    logic startNow;    // load the first trial
    logic decideNow;   // resolve the bit under trial, raise the next one
    logic serialLoad;  // serial line carries serialVal this period
    logic serialVal;
    logic dBit;        // synchronized comparator decision
  } sarStrobes_t;
endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/sar_control.sv
module sar_control
  import sar_pkg::*;
#(
  parameter int WIDTH    = 8,
  parameter bit FEED_FWD = 1'b0,
  parameter int PTR_W    = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             startConv,
  input  logic             modeCtl,
  input  logic             dSync,
  output sarStrobes_t      strobes,
  output logic [PTR_W-1:0] ptr,
  output logic             convDone
);
  localparam logic [PTR_W-1:0] IDLE_PTR = PTR_W'(WIDTH);
  localparam logic [PTR_W-1:0] MSB_PTR  = PTR_W'(WIDTH - 1);

  logic prevStart, doneFlag, ninthDue, mrHeld;
  logic active, mrHit, startNow, decideNow, lastHit, ffHit;

  always_comb begin
    active    = (ptr != IDLE_PTR);
    mrHit     = (FEED_FWD == 1'b0) && modeCtl;
    startNow  = !mrHit && startConv &&
                (!prevStart || mrHeld || ((FEED_FWD != 1'b0) && doneFlag));
    decideNow = !mrHit && !startNow && active;
    lastHit   = decideNow && (ptr == '0);
    ffHit     = (FEED_FWD != 1'b0) && modeCtl && decideNow;

    strobes.clearAll   = mrHit;
    strobes.startNow   = startNow;
    strobes.decideNow  = decideNow;
    strobes.serialLoad = (decideNow && !doneFlag) ||
                         (!mrHit && !startNow && doneFlag && ninthDue);
    strobes.serialVal  = dSync;
    strobes.dBit       = dSync;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prevStart <= 1'b0;
      ptr       <= IDLE_PTR;
      doneFlag  <= 1'b0;
      ninthDue  <= 1'b0;
      mrHeld    <= 1'b0;
    end else begin
      prevStart <= startConv;
      if (mrHit) begin
        ptr      <= IDLE_PTR;
        doneFlag <= 1'b0;
        ninthDue <= 1'b0;
        mrHeld   <= 1'b1;
      end else if (startNow) begin
        ptr      <= MSB_PTR;
        doneFlag <= 1'b0;
        ninthDue <= 1'b0;
        mrHeld   <= 1'b0;
      end else begin
        if (decideNow) ptr <= (ptr == '0) ? IDLE_PTR : ptr - PTR_W'(1);
        if ((lastHit || ffHit) && !doneFlag) begin
          doneFlag <= 1'b1;
          ninthDue <= 1'b1;
        end else if (doneFlag) begin
          ninthDue <= 1'b0;
        end
      end
    end
  end

  // Flag reaches the port half a cycle after the deciding edge
  always_ff @(negedge clk) begin
    if (rst) convDone <= 1'b0;
    else     convDone <= doneFlag;
  end

  // R3
  trial_walks_down_chk: assert property (@(posedge clk) disable iff (rst)
    (decideNow && ptr != '0) |=> (ptr == $past(ptr) - PTR_W'(1)));

  // R5
  done_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(doneFlag) |-> ($past(ptr) == '0 || ((FEED_FWD != 1'b0) && $past(modeCtl))));

  // R9
  ff_recirc_chk: assert property (@(posedge clk) disable iff (rst)
    ((FEED_FWD != 1'b0) && startConv && doneFlag) |=> (ptr == MSB_PTR));
endmodule

// File: rtl/sar_datapath.sv
module sar_datapath
  import sar_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int PTR_W = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  sarStrobes_t      strobes,
  input  logic [PTR_W-1:0] ptr,
  output logic [WIDTH-1:0] bitsQ,
  output logic             serialOut
);
  localparam logic [WIDTH-1:0] MSB_ONE = {1'b1, {(WIDTH-1){1'b0}}};

  always_ff @(posedge clk) begin
    if (rst || strobes.clearAll) begin
      bitsQ     <= '0;
      serialOut <= 1'b0;
    end else begin
      serialOut <= strobes.serialLoad ? strobes.serialVal : 1'b0;
      if (strobes.startNow) begin
        bitsQ <= MSB_ONE;
      end else if (strobes.decideNow) begin
        for (int i = 0; i < WIDTH; i++) begin
          if (i == int'(ptr))          bitsQ[i] <= strobes.dBit;
          else if (i + 1 == int'(ptr)) bitsQ[i] <= 1'b1;
        end
      end
    end
  end

  // R2
  start_loads_msb_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.startNow |=> (bitsQ == MSB_ONE));

  // R6
  clear_empties_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.clearAll |=> (bitsQ == '0 && !serialOut));

  // R8
  start_mutes_serial_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.startNow |=> !serialOut);
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int WIDTH     = 8,
  parameter bit FEED_FWD  = 1'b0,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             startConv,
  input  logic             compIn,
  input  logic             modeCtl,
  output logic [WIDTH-1:0] bitsOut,
  output logic             serialOut,
  output logic             convDone
);
  localparam int PTR_W = $clog2(WIDTH + 1);

  logic             dSync;
  sarStrobes_t      strobes;
  logic [PTR_W-1:0] ptr;

  sar_sync #(.STAGES(SYNC_DEPTH)) sync_i (
    .clk(clk), .rst(rst), .din(compIn), .dout(dSync)
  );

  sar_control #(.WIDTH(WIDTH), .FEED_FWD(FEED_FWD), .PTR_W(PTR_W)) ctrl_i (
    .clk(clk), .rst(rst), .startConv(startConv), .modeCtl(modeCtl),
    .dSync(dSync), .strobes(strobes), .ptr(ptr), .convDone(convDone)
  );

  sar_datapath #(.WIDTH(WIDTH), .PTR_W(PTR_W)) dp_i (
    .clk(clk), .rst(rst), .strobes(strobes), .ptr(ptr),
    .bitsQ(bitsOut), .serialOut(serialOut)
  );
endmodule

// File: tb/sar_ctrl_tb_top.sv
module sar_ctrl_tb_top;
  localparam int W = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic scA = 1'b0, dA = 1'b0, mcA = 1'b0;
  logic scB = 1'b0, dB = 1'b0, mcB = 1'b0;
  logic [W-1:0] qA, qB;
  logic soA, soB, eocA, eocB;
  int errs = 0, checks = 0;

  always #10 clk = ~clk;

  // master-reset variant
  sar_ctrl #(.WIDTH(W), .FEED_FWD(1'b0)) dut_i (
    .clk(clk), .rst(rst), .startConv(scA), .compIn(dA), .modeCtl(mcA),
    .bitsOut(qA), .serialOut(soA), .convDone(eocA));
  // feed-forward variant
  sar_ctrl #(.WIDTH(W), .FEED_FWD(1'b1)) dut_ff_i (
    .clk(clk), .rst(rst), .startConv(scB), .compIn(dB), .modeCtl(mcB),
    .bitsOut(qB), .serialOut(soB), .convDone(eocB));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // dv[k] is the decision at the k-th edge after start
  function automatic logic [W-1:0] expBits(input logic [9:0] dv, input int j);
    logic [W-1:0] r = '0;
    for (int i = 0; i < W; i++) begin
      int k = W - i;
      if (k <= j) r[i] = dv[k];
      else if (k == j + 1 && j < W) r[i] = 1'b1;
    end
    return r;
  endfunction

  task automatic drive(input bit ff, input bit sc, input bit d, input bit mc);
    if (ff) begin scB = sc; dB = d; mcB = mc; end
    else    begin scA = sc; dA = d; mcA = mc; end
  endtask

  task automatic tick();
    @(posedge clk); #5;
  endtask

  task automatic convRun(input bit ff, input logic [9:0] dv, input int ffAt, input bit hold);
    int doneEdge = (ffAt > 0) ? ffAt : W;
    int lastJ = (hold && ff) ? W : W + 2;
    logic [W-1:0] care = ~((W'(1) << (W - doneEdge)) - W'(1));
    logic [W-1:0] q;
    logic so, eoc, expS;
    drive(ff, 1'b0, dv[1], 1'b0); tick(); #10;
    drive(ff, 1'b1, dv[2], 1'b0);
    for (int j = 0; j <= lastJ; j++) begin
      tick();
      q  = ff ? qB : qA;
      so = ff ? soB : soA;
      chk(((q ^ expBits(dv, j)) & care) == '0, (j == 0) ? "R2" : (j > doneEdge) ? "R4" : "R3",
          "bits", int'(q & care), int'(expBits(dv, j) & care));
      expS = (j >= 1 && j <= doneEdge + 1) ? dv[j] : 1'b0;
      chk(so == expS, (j >= 1 && j <= doneEdge + 1) ? "R7" : "R8", "serial", int'(so), int'(expS));
      #10;
      eoc = ff ? eocB : eocA;
      chk(eoc == (j >= doneEdge), "R5", "eoc", int'(eoc), int'(j >= doneEdge));
      drive(ff, hold, (j + 3 <= 9) ? dv[j + 3] : 1'($urandom % 2), (ffAt == j + 1));
    end
  endtask

  task automatic report();
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
  end

  initial begin
    logic [9:0] dv;
    void'($urandom(32'd4549));
    // R1: reset state
    repeat (3) tick();
    chk(qA == '0 && qB == '0, "R1", "bits in reset", int'(qA | qB), 0);
    chk(!soA && !soB, "R1", "serial in reset", int'(soA | soB), 0);
    #10;
    chk(!eocA && !eocB, "R1", "eoc in reset", int'(eocA | eocB), 0);
    rst = 1'b0;
    for (int c = 0; c < 3; c++) begin
      drive(0, 1'b0, 1'($urandom % 2), 1'b0);
      tick();
      chk(qA == '0, "R1", "idle bits", int'(qA), 0);
      #10;
      chk(!eocA, "R1", "idle eoc", int'(eocA), 0);
    end

    // directed extremes then random words, both variants
    convRun(0, 10'h3FE, -1, 0);
    convRun(0, 10'h000, -1, 0);
    for (int n = 0; n < 6; n++) begin
      dv = 10'($urandom);
      convRun(0, dv, -1, 0);
      dv = 10'($urandom);
      convRun(1, dv, -1, 0);
    end

    // R4 / R2: start held high in master-reset mode keeps the result
    convRun(0, 10'($urandom), -1, 1);
    drive(0, 1'b0, 1'b0, 1'b0);

    // R2: retrigger in the middle of a search
    tick(); #10; drive(0, 1'b1, 1'b1, 1'b0);
    tick(); chk(qA == 8'h80, "R2", "first trial", int'(qA), 'h80); #10;
    drive(0, 1'b0, 1'b1, 1'b0);
    repeat (3) begin tick(); #10; end
    drive(0, 1'b1, 1'b1, 1'b0);
    tick();
    chk(qA == 8'h80, "R2", "retrigger", int'(qA), 'h80);
    chk(!soA, "R8", "serial at retrigger", int'(soA), 0);
    #10; drive(0, 1'b0, 1'b0, 1'b0);
    repeat (10) begin tick(); #10; end

    // R6: master reset after a finished conversion, start already high
    convRun(0, 10'($urandom), -1, 0);
    drive(0, 1'b1, 1'b1, 1'b1);
    tick();
    chk(qA == '0, "R6", "mr bits", int'(qA), 0);
    chk(!soA, "R8", "mr serial", int'(soA), 0);
    #10;
    chk(!eocA, "R6", "mr eoc", int'(eocA), 0);
    drive(0, 1'b1, 1'b1, 1'b1);
    tick(); chk(qA == '0, "R6", "mr held", int'(qA), 0); #10;
    drive(0, 1'b1, 1'b1, 1'b0);
    tick(); chk(qA == 8'h80, "R6", "start after release", int'(qA), 'h80); #10;
    drive(0, 1'b0, 1'b0, 1'b1);
    tick(); chk(qA == '0, "R6", "mr again", int'(qA), 0); #10;
    for (int c = 0; c < 3; c++) begin
      drive(0, 1'b0, 1'b1, 1'b0);
      tick(); chk(qA == '0, "R6", "stays clear", int'(qA), 0); #10;
    end
    drive(0, 1'b1, 1'b0, 1'b0);
    tick(); chk(qA == 8'h80, "R6", "start from clear", int'(qA), 'h80); #10;
    drive(0, 1'b0, 1'b0, 1'b0);
    repeat (10) begin tick(); #10; end

    // R5: feed-forward early end after five decisions
    convRun(1, 10'($urandom), 5, 0);
    convRun(1, 10'($urandom), 3, 0);

    // R9: feed-forward automatic restart with start held high
    convRun(1, 10'($urandom), -1, 1);
    tick();
    chk(qB == 8'h80, "R9", "auto restart bits", int'(qB), 'h80);
    chk(!soB, "R8", "auto restart serial", int'(soB), 0);
    #10;
    chk(!eocB, "R9", "auto restart eoc", int'(eocB), 0);
    drive(1, 1'b0, 1'b0, 1'b0);

    // R10: end-of-conversion fed back to start
    convRun(0, 10'($urandom), -1, 0);
    for (int c = 0; c < 3 * (W + 1); c++) begin
      drive(0, eocA, 1'($urandom % 2), 1'b0);
      tick();
      if (c % (W + 1) == 0) chk(qA == 8'h80, "R10", "cycle restart", int'(qA), 'h80);
      #10;
      if (c % (W + 1) == 0) chk(!eocA, "R10", "eoc low at restart", int'(eocA), 0);
      if (c % (W + 1) == W) chk(eocA, "R10", "eoc high at end", int'(eocA), 1);
    end
    drive(0, 1'b0, 1'b0, 1'b0);
    report();
  end
endmodule